// File: doc/BRIEF.md
# Two-Port Prioritized AXI4 Memory Bridge

This block lets two clients share one AXI4 memory master. The compute-core client can read and write single 32-bit words. The controller client can read words, and it has a loader path that writes words into memory. Each client starts a request with a one-cycle pulse. The block latches the address and the write data. A fixed-priority arbiter then hands the request to a single-transaction adapter, which drives either the AR/R channels or the AW/W/B channels. When the request finishes, the block sends a one-cycle acknowledge to that client only.

Read data comes from one response register inside the adapter, and both clients see it combinationally. The register loads only on a completed R handshake. Only one transaction is ever in flight, so read data seen with an acknowledge stays valid until a client issues a new read. A caller can therefore take the acknowledge and register the data on the following edge.

Top module: `mpb_bridge`

## Requirements
- R1: When both clients have a request waiting in the same idle cycle, the core client is served first. The controller request stays pending until the core transaction has been acknowledged.
- R2: At most one AXI4 transaction is active. Only one of the following is active in any cycle: the AR valid, the R ready, the AW/W valids, or the B ready.
- R3: `coreRdData` and `ctlRdData` both show the response register. The register is zero after reset and loads the R-channel data only on a cycle with both R valid and R ready high. In the cycle after an acknowledge, the data equals its value in the acknowledge cycle.
- R4: An acknowledge is a one-cycle pulse. It comes in the cycle after the R or B handshake that finishes that client's request, and only on that client's acknowledge output.
- R5: A read drives the AR channel with length 0, size code 3'b010 (four bytes) and burst code 2'b01 (incrementing).
- R6: A write drives the AW channel with length 0, size 3'b010 and burst 2'b01. It drives the W channel with all four strobe bits set and last set to 1. B ready is high from the end of AW and W until the B handshake.
- R7: The full 48-bit address, including bit 47, appears unchanged on the AR or AW address.
- R8: Consider a request pulse in cycle P that finds the block idle. Its AR or AW valid rises in cycle P+2. A request that waited behind another transaction gets its valid in the cycle after the other client's acknowledge.
- R9: While reset is applied (synchronous, active high), every AXI4 valid and ready output is low, both acknowledges are low and the read data is zero.
- R10: If a client pulses its read request and its write (core) or loader (controller) request in the same cycle, only the write is performed.
- R11: A word written by the controller loader is returned by a later core read of the same address. A core write is likewise returned by a later controller read.
- R12: Once asserted, AR valid, AW valid and W valid stay high until their handshake, and the AR address holds steady meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| coreRdReq | input | 1 | Core read request pulse |
| coreWrReq | input | 1 | Core write request pulse |
| coreAddr | input | 48 | Core request address |
| coreWrData | input | 32 | Core write word |
| coreRdData | output | 32 | Read response word (combinational view) |
| coreAck | output | 1 | Core completion pulse |
| ctlRdReq | input | 1 | Controller read request pulse |
| ctlLdReq | input | 1 | Controller loader write request pulse |
| ctlAddr | input | 48 | Controller request address |
| ctlLdData | input | 32 | Loader write word |
| ctlRdData | output | 32 | Read response word (combinational view) |
| ctlAck | output | 1 | Controller completion pulse |
| awAddr | output | 48 | AXI4 write address |
| awLen | output | 8 | AXI4 write burst length |
| awSize | output | 3 | AXI4 write beat size |
| awBurst | output | 2 | AXI4 write burst type |
| awValid | output | 1 | AXI4 write address valid |
| awReady | input | 1 | AXI4 write address ready |
| wData | output | 32 | AXI4 write data |
| wStrb | output | 4 | AXI4 write byte strobes |
| wLast | output | 1 | AXI4 last write beat |
| wValid | output | 1 | AXI4 write data valid |
| wReady | input | 1 | AXI4 write data ready |
| bValid | input | 1 | AXI4 write response valid |
| bReady | output | 1 | AXI4 write response ready |
| arAddr | output | 48 | AXI4 read address |
| arLen | output | 8 | AXI4 read burst length |
| arSize | output | 3 | AXI4 read beat size |
| arBurst | output | 2 | AXI4 read burst type |
| arValid | output | 1 | AXI4 read address valid |
| arReady | input | 1 | AXI4 read address ready |
| rData | input | 32 | AXI4 read data |
| rValid | input | 1 | AXI4 read data valid |
| rReady | output | 1 | AXI4 read data ready |

## Verification
Each error below shows up at the ports within a few cycles:
- A corrupted phase or owner register sends the acknowledge to the wrong client, or makes two channel groups active at once. Both are visible in the same cycle.
- A pending flag that is lost or set spuriously makes a transaction start without a request or never start. A missing start shows up as a timeout; a spurious one as an extra AXI4 transaction.
- A response register that follows the R channel without a handshake changes the read data in the cycle after an acknowledge.
- A mixed-up latched address or data shows up at the next AXI4 handshake, or in the word a later read returns.

The AXI4 slave uses random ready and response delays. Those delays push these errors into many different timing alignments.

// File: rtl/mpb_pkg.sv
package mpb_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_AR,
    PH_R,
    PH_AW,
    PH_B
  } phase_e;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic loadCore;  // copy latched core request into the transaction regs
    logic loadCtl;   // copy latched controller request into the transaction regs
    logic capResp;   // load the response register from the R channel
  } strobe_t;

  localparam logic [1:0] BURST_INCR = 2'b01;

endpackage

// File: rtl/mpb_ctrl.sv
module mpb_ctrl
  import mpb_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    coreRdReq,
  input  logic    coreWrReq,
  input  logic    ctlRdReq,
  input  logic    ctlLdReq,
  input  logic    arReady,
  input  logic    rValid,
  input  logic    awReady,
  input  logic    wReady,
  input  logic    bValid,
  output strobe_t strb,
  output logic    arValid,
  output logic    rReady,
  output logic    awValid,
  output logic    wValid,
  output logic    bReady,
  output logic    coreAck,
  output logic    ctlAck
);

  phase_e phase;
  logic corePend, coreIsWr, ctlPend, ctlIsWr;
  logic ownerCore, awDone, wDone;
  logic grantCore, grantCtl;
  logic awFin, wFin;

  // Fixed priority: the core wins whenever both are waiting
  assign grantCore = (phase == PH_IDLE) && corePend;
  assign grantCtl  = (phase == PH_IDLE) && !corePend && ctlPend;

  assign awFin = awDone || awReady;
  assign wFin  = wDone || wReady;

  always_comb begin
    strb.loadCore = grantCore;
    strb.loadCtl  = grantCtl;
    strb.capResp  = (phase == PH_R) && rValid;
  end

  assign arValid = (phase == PH_AR);
  assign rReady  = (phase == PH_R);
  assign awValid = (phase == PH_AW) && !awDone;
  assign wValid  = (phase == PH_AW) && !wDone;
  assign bReady  = (phase == PH_B);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      corePend  <= 1'b0;
      coreIsWr  <= 1'b0;
      ctlPend   <= 1'b0;
      ctlIsWr   <= 1'b0;
      ownerCore <= 1'b0;
      awDone    <= 1'b0;
      wDone     <= 1'b0;
      coreAck   <= 1'b0;
      ctlAck    <= 1'b0;
    end else begin
      coreAck <= 1'b0;
      ctlAck  <= 1'b0;

      if (grantCore) corePend <= 1'b0;
      if (grantCtl)  ctlPend  <= 1'b0;
      if (coreRdReq || coreWrReq) begin
        corePend <= 1'b1;
        coreIsWr <= coreWrReq;
      end
      if (ctlRdReq || ctlLdReq) begin
        ctlPend <= 1'b1;
        ctlIsWr <= ctlLdReq;
      end

      case (phase)
        PH_IDLE: begin
          awDone <= 1'b0;
          wDone  <= 1'b0;
          if (grantCore) begin
            ownerCore <= 1'b1;
            phase     <= coreIsWr ? PH_AW : PH_AR;
          end else if (grantCtl) begin
            ownerCore <= 1'b0;
            phase     <= ctlIsWr ? PH_AW : PH_AR;
          end
        end
        PH_AR: if (arReady) phase <= PH_R;
        PH_R: begin
          if (rValid) begin
            phase   <= PH_IDLE;
            coreAck <= ownerCore;
            ctlAck  <= !ownerCore;
          end
        end
        PH_AW: begin
          awDone <= awFin;
          wDone  <= wFin;
          if (awFin && wFin) phase <= PH_B;
        end
        PH_B: begin
          if (bValid) begin
            phase   <= PH_IDLE;
            coreAck <= ownerCore;
            ctlAck  <= !ownerCore;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mpb_datapath.sv
module mpb_datapath
  import mpb_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strb,
  input  logic              coreTake,
  input  logic [ADDR_W-1:0] coreAddr,
  input  logic [DATA_W-1:0] coreData,
  input  logic              ctlTake,
  input  logic [ADDR_W-1:0] ctlAddr,
  input  logic [DATA_W-1:0] ctlData,
  input  logic [DATA_W-1:0] rData,
  output logic [ADDR_W-1:0] txnAddr,
  output logic [DATA_W-1:0] txnData,
  output logic [DATA_W-1:0] respData
);

  localparam int PORTS = 2;  // index 0: core, index 1: controller

  logic [PORTS-1:0]  take, pick;
  logic [ADDR_W-1:0] inAddr   [PORTS];
  logic [DATA_W-1:0] inData   [PORTS];
  logic [ADDR_W-1:0] heldAddr [PORTS];
  logic [DATA_W-1:0] heldData [PORTS];

  assign take      = {ctlTake, coreTake};
  assign pick      = {strb.loadCtl, strb.loadCore};
  assign inAddr[0] = coreAddr;
  assign inAddr[1] = ctlAddr;
  assign inData[0] = coreData;
  assign inData[1] = ctlData;

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    always_ff @(posedge clk) begin
      if (rst) begin
        heldAddr[p] <= '0;
        heldData[p] <= '0;
      end else if (take[p]) begin
        heldAddr[p] <= inAddr[p];
        heldData[p] <= inData[p];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      txnAddr  <= '0;
      txnData  <= '0;
      respData <= '0;
    end else begin
      if (pick[0]) begin
        txnAddr <= heldAddr[0];
        txnData <= heldData[0];
      end else if (pick[1]) begin
        txnAddr <= heldAddr[1];
        txnData <= heldData[1];
      end
      if (strb.capResp) respData <= rData;
    end
  end

endmodule

// File: rtl/mpb_bridge.sv
module mpb_bridge
  import mpb_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  coreRdReq,
  input  logic                  coreWrReq,
  input  logic [ADDR_W-1:0]     coreAddr,
  input  logic [DATA_W-1:0]     coreWrData,
  output logic [DATA_W-1:0]     coreRdData,
  output logic                  coreAck,
  input  logic                  ctlRdReq,
  input  logic                  ctlLdReq,
  input  logic [ADDR_W-1:0]     ctlAddr,
  input  logic [DATA_W-1:0]     ctlLdData,
  output logic [DATA_W-1:0]     ctlRdData,
  output logic                  ctlAck,
  output logic [ADDR_W-1:0]     awAddr,
  output logic [7:0]            awLen,
  output logic [2:0]            awSize,
  output logic [1:0]            awBurst,
  output logic                  awValid,
  input  logic                  awReady,
  output logic [DATA_W-1:0]     wData,
  output logic [DATA_W/8-1:0]   wStrb,
  output logic                  wLast,
  output logic                  wValid,
  input  logic                  wReady,
  input  logic                  bValid,
  output logic                  bReady,
  output logic [ADDR_W-1:0]     arAddr,
  output logic [7:0]            arLen,
  output logic [2:0]            arSize,
  output logic [1:0]            arBurst,
  output logic                  arValid,
  input  logic                  arReady,
  input  logic [DATA_W-1:0]     rData,
  input  logic                  rValid,
  output logic                  rReady
);

  localparam int          STRB_W    = DATA_W / 8;
  localparam logic [2:0]  BEAT_SIZE = 3'($clog2(STRB_W));

  strobe_t           strb;
  logic [ADDR_W-1:0] txnAddr;
  logic [DATA_W-1:0] txnData;
  logic [DATA_W-1:0] respData;

  mpb_ctrl i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .coreRdReq(coreRdReq),
    .coreWrReq(coreWrReq),
    .ctlRdReq (ctlRdReq),
    .ctlLdReq (ctlLdReq),
    .arReady  (arReady),
    .rValid   (rValid),
    .awReady  (awReady),
    .wReady   (wReady),
    .bValid   (bValid),
    .strb     (strb),
    .arValid  (arValid),
    .rReady   (rReady),
    .awValid  (awValid),
    .wValid   (wValid),
    .bReady   (bReady),
    .coreAck  (coreAck),
    .ctlAck   (ctlAck)
  );

  mpb_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dp (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .coreTake(coreRdReq || coreWrReq),
    .coreAddr(coreAddr),
    .coreData(coreWrData),
    .ctlTake (ctlRdReq || ctlLdReq),
    .ctlAddr (ctlAddr),
    .ctlData (ctlLdData),
    .rData   (rData),
    .txnAddr (txnAddr),
    .txnData (txnData),
    .respData(respData)
  );

  // Both clients see the held response register directly
  assign coreRdData = respData;
  assign ctlRdData  = respData;

  assign arAddr  = txnAddr;
  assign arLen   = 8'd0;
  assign arSize  = BEAT_SIZE;
  assign arBurst = BURST_INCR;

  assign awAddr  = txnAddr;
  assign awLen   = 8'd0;
  assign awSize  = BEAT_SIZE;
  assign awBurst = BURST_INCR;
  assign wData   = txnData;
  assign wStrb   = '1;
  assign wLast   = 1'b1;

endmodule

// File: rtl/mpb_checker.sv
module mpb_checker #(
  parameter int ADDR_W = 48,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              coreRdReq,
  input logic              coreWrReq,
  input logic              coreAck,
  input logic              ctlAck,
  input logic              loadCtl,
  input logic              arValid,
  input logic              arReady,
  input logic [ADDR_W-1:0] arAddr,
  input logic              rValid,
  input logic              rReady,
  input logic              awValid,
  input logic              awReady,
  input logic              wValid,
  input logic              wReady,
  input logic              bValid,
  input logic              bReady,
  input logic [DATA_W-1:0] coreRdData
);

  logic coreWait;

  always_ff @(posedge clk) begin
    if (rst) coreWait <= 1'b0;
    else if (coreRdReq || coreWrReq) coreWait <= 1'b1;
    else if (coreAck) coreWait <= 1'b0;
  end

  // R1
  core_first_chk: assert property (@(posedge clk) disable iff (rst)
    loadCtl |-> !(coreWait && !coreAck));

  // R2
  one_txn_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({arValid, rReady, awValid || wValid, bReady}));

  // R3
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rValid && rReady)) |-> $stable(coreRdData));

  // R4
  ack_src_chk: assert property (@(posedge clk) disable iff (rst)
    ((coreAck || ctlAck) && !$past(rst)) |-> $past((rValid && rReady) || (bValid && bReady)));

  // R4
  ack_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(coreAck && ctlAck));

  // R12
  ar_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (arValid && !arReady) |=> (arValid && $stable(arAddr)));

  // R12
  aw_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (awValid && !awReady) |=> awValid);

  // R12
  w_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wValid && !wReady) |=> wValid);

endmodule

bind mpb_bridge mpb_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .coreRdReq (coreRdReq),
  .coreWrReq (coreWrReq),
  .coreAck   (coreAck),
  .ctlAck    (ctlAck),
  .loadCtl   (strb.loadCtl),
  .arValid   (arValid),
  .arReady   (arReady),
  .arAddr    (arAddr),
  .rValid    (rValid),
  .rReady    (rReady),
  .awValid   (awValid),
  .awReady   (awReady),
  .wValid    (wValid),
  .wReady    (wReady),
  .bValid    (bValid),
  .bReady    (bReady),
  .coreRdData(coreRdData)
);

// File: tb/test_mpb_bridge.sv
module test_mpb_bridge;

  localparam int AW = 48;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic coreRdReq = 0, coreWrReq = 0, ctlRdReq = 0, ctlLdReq = 0;
  logic [AW-1:0] coreAddr = '0, ctlAddr = '0;
  logic [DW-1:0] coreWrData = '0, ctlLdData = '0;
  logic [DW-1:0] coreRdData, ctlRdData;
  logic coreAck, ctlAck;
  logic [AW-1:0] awAddr, arAddr;
  logic [7:0] awLen, arLen;
  logic [2:0] awSize, arSize;
  logic [1:0] awBurst, arBurst;
  logic awValid, wValid, bReady, arValid, rReady, wLast;
  logic [DW-1:0] wData;
  logic [DW/8-1:0] wStrb;
  logic awReady = 0, wReady = 0, bValid = 0, arReady = 0, rValid = 0;
  logic [DW-1:0] rData = '0;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int coreAckCyc = 0, ctlAckCyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mpb_bridge #(.ADDR_W(AW), .DATA_W(DW)) i_mpb_bridge (
    .clk(clk), .rst(rst),
    .coreRdReq(coreRdReq), .coreWrReq(coreWrReq), .coreAddr(coreAddr),
    .coreWrData(coreWrData), .coreRdData(coreRdData), .coreAck(coreAck),
    .ctlRdReq(ctlRdReq), .ctlLdReq(ctlLdReq), .ctlAddr(ctlAddr),
    .ctlLdData(ctlLdData), .ctlRdData(ctlRdData), .ctlAck(ctlAck),
    .awAddr(awAddr), .awLen(awLen), .awSize(awSize), .awBurst(awBurst),
    .awValid(awValid), .awReady(awReady),
    .wData(wData), .wStrb(wStrb), .wLast(wLast), .wValid(wValid), .wReady(wReady),
    .bValid(bValid), .bReady(bReady),
    .arAddr(arAddr), .arLen(arLen), .arSize(arSize), .arBurst(arBurst),
    .arValid(arValid), .arReady(arReady),
    .rData(rData), .rValid(rValid), .rReady(rReady)
  );

  // ---------------- AXI4 slave model ----------------
  logic [DW-1:0] mem    [logic [AW-1:0]];
  logic [DW-1:0] shadow [logic [AW-1:0]];
  logic [AW-1:0] lastArAddr, lastAwAddr, slvRdAddr, slvAwAddr;
  logic [7:0]    lastArLen, lastAwLen;
  logic [2:0]    lastArSize, lastAwSize;
  logic [1:0]    lastArBurst, lastAwBurst;
  logic [DW-1:0] lastWData, slvWData;
  logic [DW/8-1:0] lastWStrb;
  logic          lastWLast;

  initial begin
    bit hsAr = 0, hsR = 0, hsAw = 0, hsW = 0, hsB = 0;
    bit rPend = 0, awGot = 0, wGot = 0, bPend = 0;
    int rDelay = 0, bDelay = 0;
    forever begin
      @(negedge clk);
      if (rst) begin
        rPend = 0; awGot = 0; wGot = 0; bPend = 0;
        arReady = 0; awReady = 0; wReady = 0; rValid = 0; bValid = 0;
        hsAr = 0; hsR = 0; hsAw = 0; hsW = 0; hsB = 0;
      end else begin
        if (hsAr) begin
          rPend = 1; slvRdAddr = lastArAddr; rDelay = int'($urandom % 4);
        end
        if (hsR) rValid = 0;
        if (hsAw) begin awGot = 1; slvAwAddr = lastAwAddr; end
        if (hsW) begin wGot = 1; slvWData = lastWData; end
        if (hsB) bValid = 0;
        if (awGot && wGot) begin
          mem[slvAwAddr] = slvWData;
          awGot = 0; wGot = 0; bPend = 1; bDelay = int'($urandom % 3);
        end
        if (rPend) begin
          if (rDelay == 0) begin
            rValid = 1;
            rData  = mem.exists(slvRdAddr) ? mem[slvRdAddr] : '0;
            rPend  = 0;
          end else rDelay--;
        end
        if (bPend) begin
          if (bDelay == 0) begin bValid = 1; bPend = 0; end
          else bDelay--;
        end
        arReady = $urandom % 2;
        awReady = $urandom % 2;
        wReady  = $urandom % 2;
        if (!rValid) rData = $urandom;  // noise on an idle R channel
      end
      #1;
      hsAr = arValid && arReady;
      hsR  = rValid && rReady;
      hsAw = awValid && awReady;
      hsW  = wValid && wReady;
      hsB  = bValid && bReady;
      if (hsAr) begin
        lastArAddr = arAddr; lastArLen = arLen; lastArSize = arSize; lastArBurst = arBurst;
      end
      if (hsAw) begin
        lastAwAddr = awAddr; lastAwLen = awLen; lastAwSize = awSize; lastAwBurst = awBurst;
      end
      if (hsW) begin
        lastWData = wData; lastWStrb = wStrb; lastWLast = wLast;
      end
    end
  end

  // ---------------- bench helpers ----------------
  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] expRead(input logic [AW-1:0] a);
    return shadow.exists(a) ? shadow[a] : '0;
  endfunction

  function automatic logic [AW-1:0] pickAddr(input int k);
    return {(k % 2 == 1) ? 16'h8000 : 16'h0000, 32'h0000_1000 + 32'(k * 4)};
  endfunction

  // wr: write/load; both: also pulse the read request (R10); lat: check start latency (R8)
  task automatic clientOp(input bit isCore, input bit wr, input bit both, input bit lat,
                          input logic [AW-1:0] a, input logic [DW-1:0] d);
    int n = 0;
    logic [DW-1:0] held;
    @(negedge clk);
    if (isCore) begin
      coreAddr = a; coreWrData = d; coreWrReq = wr; coreRdReq = !wr || both;
    end else begin
      ctlAddr = a; ctlLdData = d; ctlLdReq = wr; ctlRdReq = !wr || both;
    end
    @(negedge clk);
    coreRdReq = isCore ? 1'b0 : coreRdReq;
    coreWrReq = isCore ? 1'b0 : coreWrReq;
    ctlRdReq  = isCore ? ctlRdReq : 1'b0;
    ctlLdReq  = isCore ? ctlLdReq : 1'b0;
    if (lat) begin
      chk((wr ? awValid : arValid) == 1'b0, "R8 no start in P+1", 64'(wr ? awValid : arValid), 0);
      @(negedge clk);
      chk((wr ? awValid : arValid) == 1'b1, "R8 start in P+2", 64'(wr ? awValid : arValid), 1);
    end
    while (!(isCore ? coreAck : ctlAck) && n < 300) begin
      @(negedge clk);
      n++;
    end
    chk(n < 300, "R4 ack arrives", 64'(n), 0);
    if (isCore) coreAckCyc = cyc; else ctlAckCyc = cyc;
    chk(!(coreAck && ctlAck), "R4 ack on one client only", 64'({coreAck, ctlAck}), 0);
    if (wr) begin
      chk(lastAwAddr == a, "R7 AW address passthrough", 64'(lastAwAddr), 64'(a));
      chk(lastWData == d, "R6 W data", 64'(lastWData), 64'(d));
      chk(lastWStrb == '1 && lastWLast == 1'b1, "R6 W strobes and last",
          64'({lastWStrb, lastWLast}), 64'h1F);
      chk(lastAwLen == 8'd0 && lastAwSize == 3'b010 && lastAwBurst == 2'b01,
          "R6 AW len/size/burst", 64'({lastAwLen, lastAwSize, lastAwBurst}), 64'h009);
      shadow[a] = d;
    end else begin
      held = isCore ? coreRdData : ctlRdData;
      chk(lastArAddr == a, "R7 AR address passthrough", 64'(lastArAddr), 64'(a));
      chk(lastArLen == 8'd0 && lastArSize == 3'b010 && lastArBurst == 2'b01,
          "R5 AR len/size/burst", 64'({lastArLen, lastArSize, lastArBurst}), 64'h009);
      chk(held == expRead(a), "R11 read returns stored word", 64'(held), 64'(expRead(a)));
      chk(coreRdData == ctlRdData, "R3 both views equal", 64'(coreRdData), 64'(ctlRdData));
    end
    @(negedge clk);
    chk((isCore ? coreAck : ctlAck) == 1'b0, "R4 ack is one cycle", 64'(isCore ? coreAck : ctlAck), 0);
    if (!wr)
      chk(coreRdData == held, "R3 data stable after ack", 64'(coreRdData), 64'(held));
  endtask

  // Checks that the waiting controller request starts right after the core ack (R8)
  task automatic watchHandoff(input bit ctlWr);
    int n = 0;
    while (!coreAck && n < 300) begin
      @(negedge clk);
      n++;
    end
    @(negedge clk);
    chk((ctlWr ? awValid : arValid) == 1'b1, "R8 waiting request starts after ack",
        64'(ctlWr ? awValid : arValid), 1);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [AW-1:0] a0, a1;
    void'($urandom(32'hC0FFEE));
    repeat (3) @(negedge clk);
    // R9: state while reset is applied
    chk({arValid, rReady, awValid, wValid, bReady} == 5'b0, "R9 valids low in reset",
        64'({arValid, rReady, awValid, wValid, bReady}), 0);
    chk(!coreAck && !ctlAck, "R9 acks low in reset", 64'({coreAck, ctlAck}), 0);
    chk(coreRdData == '0, "R9 read data zero in reset", 64'(coreRdData), 0);
    rst = 1'b0;
    @(negedge clk);

    // R11: loader write then core read; R7: bit 47 set
    a0 = 48'h8000_0000_0080;
    clientOp(1'b0, 1'b1, 1'b0, 1'b1, a0, 32'hA5A5_5A5A);
    clientOp(1'b1, 1'b0, 1'b0, 1'b1, a0, '0);
    a1 = 48'hFFFF_FFFF_FFFC;
    clientOp(1'b1, 1'b1, 1'b0, 1'b1, a1, 32'h1234_5678);
    clientOp(1'b0, 1'b0, 1'b0, 1'b1, a1, '0);
    clientOp(1'b1, 1'b0, 1'b0, 1'b1, 48'h0000_0000_0040, '0);  // never written: zero

    // R10: read and write pulsed together on each client
    clientOp(1'b1, 1'b1, 1'b1, 1'b1, 48'h0000_0000_0100, 32'hDEAD_BEEF);
    clientOp(1'b1, 1'b0, 1'b0, 1'b1, 48'h0000_0000_0100, '0);
    clientOp(1'b0, 1'b1, 1'b1, 1'b1, 48'h0000_0000_0104, 32'hCAFE_F00D);
    clientOp(1'b0, 1'b0, 1'b0, 1'b1, 48'h0000_0000_0104, '0);

    // R1: simultaneous reads, then simultaneous writes
    fork
      clientOp(1'b1, 1'b0, 1'b0, 1'b0, a0, '0);
      clientOp(1'b0, 1'b0, 1'b0, 1'b0, a1, '0);
      watchHandoff(1'b0);
    join
    chk(coreAckCyc < ctlAckCyc, "R1 core read served first", 64'(coreAckCyc), 64'(ctlAckCyc));
    fork
      clientOp(1'b1, 1'b1, 1'b0, 1'b0, 48'h0000_0000_0200, 32'h1111_2222);
      clientOp(1'b0, 1'b1, 1'b0, 1'b0, 48'h0000_0000_0204, 32'h3333_4444);
      watchHandoff(1'b1);
    join
    chk(coreAckCyc < ctlAckCyc, "R1 core write served first", 64'(coreAckCyc), 64'(ctlAckCyc));
    clientOp(1'b0, 1'b0, 1'b0, 1'b1, 48'h0000_0000_0200, '0);
    clientOp(1'b1, 1'b0, 1'b0, 1'b1, 48'h0000_0000_0204, '0);

    // Constrained random traffic, one client at a time
    for (int i = 0; i < 80; i++) begin
      bit isCore = $urandom % 2;
      bit wr     = $urandom % 2;
      clientOp(isCore, wr, 1'b0, 1'b1, pickAddr(int'($urandom % 8)), $urandom);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule